// File: doc/BRIEF.md
# Rolling-Shutter Row Sequencer

The sequencer drives the digital control lines of a pixel matrix that is read one row at a time in rolling-shutter fashion. A row counter and a phase counter walk the matrix at a fixed number of clocks per row. Each row has four lines: a row select, a longer power-on window, a clamp pulse, and a select shared by its group of rows. The column discriminators that sample the selected row receive a read, a calibrate and a latch strobe, and the row index is presented alongside the latch.

Power and group windows open one row slot early, so the pixels settle before they are read. As a result, neighbouring windows overlap. The sequencer wraps from the last row back to row 0 and flags each new frame with a one-cycle pulse. A synchronous enable freezes the scan, and a synchronous reset restarts it at row 0. Matrix height, group size, slot length and strobe lengths are parameters.

Top module: `rolling_row_seq`

## Requirements
- R1: Exactly one `row_sel` line is high, the one for the current row. It stays high for the `SLOT` (default 16) enabled clocks of that row's slot. `row_idx` carries the same row number.
- R2: `pwr_on[i]` is high while row i is current and while row i-1 (row `ROWS`-1 for i = 0) is current. This gives a window of two slots (32 clocks by default) that opens one slot before the row's select.
- R3: `grp_sel[g]` covers rows g*`GROUP` to g*`GROUP`+`GROUP`-1. It is high while any of these rows is current, and also during the slot of the row just before the group's first row, wrapping modulo `ROWS`. At most two group lines are ever high.
- R4: `clamp[i]` is high only for the current row i, in phases 0 to `CLAMP_LEN`-1 (default 0..2) of the slot, and only while `en` is high.
- R5: While `en` is high, the slot phase decodes as follows: `disc_rd` in phases `CLAMP_LEN` to `CLAMP_LEN`+`RD_LEN`-1 (default 3..5); `disc_cal` from the next phase up to `SLOT`-2 (default 6..14); `disc_latch` in phase `SLOT`-1 only. `row_idx` is valid while `disc_latch` is high.
- R6: Each enabled clock advances the phase by one. After phase `SLOT`-1 the row advances by one, and after row `ROWS`-1 (default 575) the row returns to 0.
- R7: `sof` is high for exactly one cycle in two cases: the first cycle after reset is released, and the first cycle of row 0 reached by a wrap. It stays low at all other times, including during stalls.
- R8: While `en` is low, row and phase hold. `row_sel`, `pwr_on`, `grp_sel` and `row_idx` keep their values, and `clamp` and all discriminator strobes are low.
- R9: A synchronous `rst` high at a clock edge puts the sequencer in row 0, phase 0, from any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance enable; low stalls the scan |
| row_sel | output | ROWS | Per-row select, one-hot |
| pwr_on | output | ROWS | Per-row power window |
| clamp | output | ROWS | Per-row clamp pulse |
| grp_sel | output | ROWS/GROUP | Per-group select |
| disc_rd | output | 1 | Discriminator read strobe |
| disc_cal | output | 1 | Discriminator calibrate strobe |
| disc_latch | output | 1 | Discriminator latch strobe |
| row_idx | output | clog2(ROWS) | Current row number |
| sof | output | 1 | Start-of-frame pulse |

## Verification
Two events can fall in the same cycle: the frame wrap and a stall. The bench lowers `en` exactly when the last row sits in its latch phase. The expected result is that the latch disappears, all row and group lines freeze, and `sof` appears only in the cycle after the delayed enabled wrap, lasting a single cycle. The same collision is checked between a mid-frame reset and random stalls, judged against a behavioural model that is compared against every output on every clock.

// File: rtl/rs_seq_pkg.sv
package rs_seq_pkg;

  // Row preceding row r in a matrix of n rows, wrapping at the top.
  function automatic int prev_row(input int r, input int n);
    return (r == 0) ? n - 1 : r - 1;
  endfunction

  // Group a row belongs to, for groups of gsz consecutive rows.
  function automatic int group_of(input int r, input int gsz);
    return r / gsz;
  endfunction

  // Phase classes inside one row slot.
  typedef enum logic [1:0] {
    PH_CLAMP = 2'd0,
    PH_READ  = 2'd1,
    PH_CAL   = 2'd2,
    PH_LATCH = 2'd3
  } phase_kind_e;

  function automatic phase_kind_e kind_of(input int ph, input int slot,
                                          input int clen, input int rlen);
    if (ph < clen)        return PH_CLAMP;
    if (ph < clen + rlen) return PH_READ;
    if (ph < slot - 1)    return PH_CAL;
    return PH_LATCH;
  endfunction

endpackage

// File: rtl/rs_slot_timer.sv
module rs_slot_timer #(
  parameter int ROWS = 576,
  parameter int SLOT = 16,
  localparam int RW = $clog2(ROWS),
  localparam int PW = $clog2(SLOT)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  output logic [RW-1:0] row_q,
  output logic [PW-1:0] phase_q,
  output logic          sof_q
);

  localparam logic [RW-1:0] ROW_LAST = RW'(ROWS - 1);
  localparam logic [PW-1:0] PH_LAST  = PW'(SLOT - 1);

  // Named events for the checks below.
  logic slot_end, frame_end;
  assign slot_end  = (phase_q == PH_LAST);
  assign frame_end = slot_end && (row_q == ROW_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      row_q   <= '0;
      phase_q <= '0;
      sof_q   <= 1'b1;
    end else begin
      sof_q <= 1'b0;
      if (en) begin
        if (slot_end) begin
          phase_q <= '0;
          if (frame_end) begin
            row_q <= '0;
            sof_q <= 1'b1;
          end else begin
            row_q <= row_q + 1'b1;
          end
        end else begin
          phase_q <= phase_q + 1'b1;
        end
      end
    end
  end

  p_phase_step_r6: assert property (@(posedge clk) disable iff (rst)
    (en && !slot_end) |=> (phase_q == $past(phase_q) + 1'b1) && $stable(row_q));
  p_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    (en && frame_end) |=> (row_q == '0) && (phase_q == '0) && sof_q);
  p_sof_single_r7: assert property (@(posedge clk) disable iff (rst)
    sof_q |=> !sof_q);
  p_stall_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(row_q) && $stable(phase_q) && !sof_q);
  p_reset_r9: assert property (@(posedge clk)
    rst |=> (row_q == '0) && (phase_q == '0));

endmodule

// File: rtl/rs_disc_strobe.sv
module rs_disc_strobe
  import rs_seq_pkg::*;
#(
  parameter int SLOT      = 16,
  parameter int CLAMP_LEN = 3,
  parameter int RD_LEN    = 3,
  localparam int PW = $clog2(SLOT)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [PW-1:0] phase,
  output logic          clamp_win,
  output logic          rd,
  output logic          cal,
  output logic          latch
);

  phase_kind_e kind;

  always_comb begin
    kind      = kind_of(int'(phase), SLOT, CLAMP_LEN, RD_LEN);
    clamp_win = en && (kind == PH_CLAMP);
    rd        = en && (kind == PH_READ);
    cal       = en && (kind == PH_CAL);
    latch     = en && (kind == PH_LATCH);
  end

  p_strobe_excl_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({clamp_win, rd, cal, latch}));
  p_latch_single_r5: assert property (@(posedge clk) disable iff (rst)
    latch |=> !latch);
  p_stall_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !en |-> !(clamp_win || rd || cal || latch));

endmodule

// File: rtl/rs_row_drive.sv
module rs_row_drive
  import rs_seq_pkg::*;
#(
  parameter int ROWS = 576,
  localparam int RW = $clog2(ROWS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [RW-1:0]   row,
  input  logic            clamp_win,
  output logic [ROWS-1:0] row_sel,
  output logic [ROWS-1:0] pwr_on,
  output logic [ROWS-1:0] clamp
);

  for (genvar i = 0; i < ROWS; i++) begin : g_row
    localparam int PREV = prev_row(i, ROWS);
    assign row_sel[i] = (row == RW'(i));
    assign pwr_on[i]  = row_sel[i] || (row == RW'(PREV));
    assign clamp[i]   = row_sel[i] && clamp_win;
  end

  p_sel_onehot_r1: assert property (@(posedge clk) disable iff (rst)
    $onehot(row_sel));
  p_sel_in_pwr_r2: assert property (@(posedge clk) disable iff (rst)
    (row_sel & ~pwr_on) == '0);
  p_pwr_two_r2: assert property (@(posedge clk) disable iff (rst)
    $countones(pwr_on) == ((ROWS > 1) ? 2 : 1));
  p_clamp_in_sel_r4: assert property (@(posedge clk) disable iff (rst)
    (clamp & ~row_sel) == '0);

endmodule

// File: rtl/rs_group_drive.sv
module rs_group_drive
  import rs_seq_pkg::*;
#(
  parameter int ROWS  = 576,
  parameter int GROUP = 16,
  localparam int RW   = $clog2(ROWS),
  localparam int NGRP = ROWS / GROUP
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [RW-1:0]   row,
  output logic [NGRP-1:0] grp_sel
);

  int cur_grp;
  always_comb cur_grp = group_of(int'(row), GROUP);

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam int LEAD = prev_row(g * GROUP, ROWS);
    assign grp_sel[g] = (cur_grp == g) || (row == RW'(LEAD));
  end

  p_grp_count_r3: assert property (@(posedge clk) disable iff (rst)
    ($countones(grp_sel) >= 1) && ($countones(grp_sel) <= 2));

endmodule

// File: rtl/rolling_row_seq.sv
module rolling_row_seq #(
  parameter int ROWS      = 576,
  parameter int GROUP     = 16,
  parameter int SLOT      = 16,
  parameter int CLAMP_LEN = 3,
  parameter int RD_LEN    = 3,
  localparam int RW   = $clog2(ROWS),
  localparam int PW   = $clog2(SLOT),
  localparam int NGRP = ROWS / GROUP
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  output logic [ROWS-1:0] row_sel,
  output logic [ROWS-1:0] pwr_on,
  output logic [ROWS-1:0] clamp,
  output logic [NGRP-1:0] grp_sel,
  output logic            disc_rd,
  output logic            disc_cal,
  output logic            disc_latch,
  output logic [RW-1:0]   row_idx,
  output logic            sof
);

  logic [RW-1:0] row_q;
  logic [PW-1:0] phase_q;
  logic          clamp_win;

  rs_slot_timer #(.ROWS(ROWS), .SLOT(SLOT)) u_timer (
    .clk(clk), .rst(rst), .en(en),
    .row_q(row_q), .phase_q(phase_q), .sof_q(sof)
  );

  rs_disc_strobe #(.SLOT(SLOT), .CLAMP_LEN(CLAMP_LEN), .RD_LEN(RD_LEN)) u_strobe (
    .clk(clk), .rst(rst), .en(en), .phase(phase_q),
    .clamp_win(clamp_win), .rd(disc_rd), .cal(disc_cal), .latch(disc_latch)
  );

  rs_row_drive #(.ROWS(ROWS)) u_rows (
    .clk(clk), .rst(rst), .row(row_q), .clamp_win(clamp_win),
    .row_sel(row_sel), .pwr_on(pwr_on), .clamp(clamp)
  );

  rs_group_drive #(.ROWS(ROWS), .GROUP(GROUP)) u_groups (
    .clk(clk), .rst(rst), .row(row_q), .grp_sel(grp_sel)
  );

  assign row_idx = row_q;

  // Latch presents the row whose select is high (R5 with R1).
  p_latch_row_r5: assert property (@(posedge clk) disable iff (rst)
    disc_latch |-> row_sel[row_idx]);

endmodule

// File: tb/rolling_row_seq_bench.sv
module rolling_row_seq_bench;
  localparam int ROWS = 576, GROUP = 16, SLOT = 16, CL = 3, RL = 3;
  localparam int RW = $clog2(ROWS), NGRP = ROWS / GROUP;

  logic clk = 1'b0, rst = 1'b1, en = 1'b1;
  logic [ROWS-1:0] row_sel, pwr_on, clamp;
  logic [NGRP-1:0] grp_sel;
  logic disc_rd, disc_cal, disc_latch, sof;
  logic [RW-1:0] row_idx;

  always #10 clk = ~clk;

  rolling_row_seq u_rolling_row_seq (
    .clk(clk), .rst(rst), .en(en), .row_sel(row_sel), .pwr_on(pwr_on),
    .clamp(clamp), .grp_sel(grp_sel), .disc_rd(disc_rd), .disc_cal(disc_cal),
    .disc_latch(disc_latch), .row_idx(row_idx), .sof(sof)
  );

  int total = 0, bad = 0;
  int mr = 0, mp = 0;
  bit msof = 0, started = 0, done = 0;

  // Behavioural reference: integer row and phase.
  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      mr = 0; mp = 0; msof = 1;
    end else begin
      msof = 0;
      if (en) begin
        if (mp == SLOT - 1) begin
          mp = 0;
          if (mr == ROWS - 1) begin mr = 0; msof = 1; end
          else mr = mr + 1;
        end else mp = mp + 1;
      end
    end
  end

  task automatic chk(input string req, input logic [1023:0] act, input logic [1023:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s t=%0t actual=%0h expected=%0h", req, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      logic [ROWS-1:0] es, ep, ec;
      logic [NGRP-1:0] eg;
      for (int i = 0; i < ROWS; i++) begin
        es[i] = (mr == i);
        ep[i] = (mr == i) || (mr == ((i == 0) ? ROWS - 1 : i - 1));
        ec[i] = (mr == i) && en && (mp < CL);
      end
      for (int g = 0; g < NGRP; g++) begin
        int first;
        first = g * GROUP;
        eg[g] = (mr >= first && mr < first + GROUP) ||
                (mr == ((first == 0) ? ROWS - 1 : first - 1));
      end
      chk("R1 row_sel", 1024'(row_sel), 1024'(es));
      chk("R6 row_idx", 1024'(row_idx), 1024'(mr));
      chk("R2 pwr_on", 1024'(pwr_on), 1024'(ep));
      chk("R3 grp_sel", 1024'(grp_sel), 1024'(eg));
      chk("R4 clamp", 1024'(clamp), 1024'(ec));
      chk("R5 strobes rd/cal/latch", 1024'({disc_rd, disc_cal, disc_latch}),
          1024'({en && mp >= CL && mp < CL + RL,
                 en && mp >= CL + RL && mp < SLOT - 1,
                 en && mp == SLOT - 1}));
      chk("R7 sof", 1024'(sof), 1024'(msof));
    end
  end

  task automatic finish_run();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  initial begin
    step(3);
    // R9: reset state seen during the reset cycles by the model compare.
    rst = 1'b0;
    // Full frame with no stall: wrap and sof (R6, R7).
    step(ROWS * SLOT + 40);
    // Random stalls, R8.
    for (int k = 0; k < ROWS * SLOT / 2; k++) begin
      en = ($urandom % 4) != 0;
      step(1);
    end
    en = 1'b1;
    // Collision: stall exactly at the last row's latch phase (R7 with R8).
    while (!(mr == ROWS - 1 && mp == SLOT - 1)) step(1);
    en = 1'b0; step(3);
    en = 1'b1; step(SLOT * 3);
    // Stall while a row sits in its latch phase mid-frame (R5 with R8).
    while (mp != SLOT - 1) step(1);
    en = 1'b0; step(2);
    en = 1'b1; step(SLOT * 40 + 5);
    // Mid-frame reset under random stalls (R9).
    for (int k = 0; k < 300; k++) begin
      en = ($urandom % 3) != 0;
      rst = (k == 150 || k == 151);
      step(1);
    end
    rst = 1'b0; en = 1'b1;
    step(200);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

endmodule